// File: doc/BRIEF.md
# Two-Phase Transmit-Enable Cycle Generator

This block produces a transmit gating waveform by stepping through two programmable cycle patterns. Pattern A and pattern B each have a high-time count, a low-time count and a repetition count. The generator plays pattern A the programmed number of times and then pattern B the programmed number of times. It then returns to pattern A and keeps looping.

Nothing runs after reset. A channel update pulse clears every counter and starts the waveform in pattern A with the enable high. A later update restarts the sequence from the same point.

A frame-strobe pin sits beside the enable output. When pin control is enabled, a 2-bit selector decides what drives that pin: its ordinary default source, the update pulse, or the generated enable. A synchronizing control bit adds one register stage to the enable before it reaches either output. This removes edge glitches.

Top module: `txen_cycle_gen`

## Requirements
- R1: After reset, and until the first update pulse, `txen_o` is low whatever the configuration inputs hold.
- R2: In the clock cycle right after an update edge, `txen_o` is high, provided either repetition count is nonzero. The sequence starts in pattern A when its repetition count is nonzero.
- R3: Within a pattern, the enable stays high for the high count in clocks and then low for the low count in clocks. A count of zero behaves as one clock.
- R4: A pattern repeats its high/low pair for its repetition count. Control then passes to the other pattern, and after pattern B the sequence returns to pattern A, indefinitely.
- R5: A pattern with repetition count zero is skipped. If both repetition counts are zero, an update leaves `txen_o` held low.
- R6: An update received while the waveform runs restarts it at once from its initial point, discarding the current position.
- R7: With `sync_en` high, `txen_o` equals the internally generated enable delayed by exactly one clock. With `sync_en` low, there is no delay.
- R8: With `pin_ctl_en` low, `fs_o` equals `fs_default_i` for every value of `strobe_mode`.
- R9: With `pin_ctl_en` high, `strobe_mode` selects the source of `fs_o`:
  - 2'b00 and 2'b01 pass `fs_default_i`.
  - 2'b10 passes `upd_i`.
  - 2'b11 passes `txen_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_high_cnt | input | 16 | Pattern A high time in clocks |
| pa_low_cnt | input | 16 | Pattern A low time in clocks |
| pb_high_cnt | input | 16 | Pattern B high time in clocks |
| pb_low_cnt | input | 16 | Pattern B low time in clocks |
| pa_reps | input | 5 | Pattern A repetition count |
| pb_reps | input | 5 | Pattern B repetition count |
| strobe_mode | input | 2 | Frame-strobe source selector |
| upd_i | input | 1 | Channel update pulse; restarts the generator |
| pin_ctl_en | input | 1 | Lets `strobe_mode` take over the frame-strobe pin |
| sync_en | input | 1 | Adds a register stage on the enable |
| fs_default_i | input | 1 | Default frame-strobe source |
| txen_o | output | 1 | Generated transmit enable |
| fs_o | output | 1 | Frame-strobe pin output |

## Verification
The bound checks on the phase counter and the repetition counter assume that the counts and repetition fields stay constant between updates. Those checks are therefore disabled in any cycle where an update is captured. The stimulus keeps to this rule: it changes the configuration only in the same cycle in which it raises `upd_i`, and holds it steady until the next update. The synchronizer check also assumes `sync_en` has been steady for one clock, and the bench changes `sync_en` only while the generator is idle or between runs.

// File: rtl/txen_pkg.sv
package txen_pkg;

    localparam int CNT_W = 16;
    localparam int REP_W = 5;
    localparam int SEL_W = 2;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    typedef enum logic [SEL_W-1:0] {
        FS_KEEP_A = 2'b00,
        FS_KEEP_B = 2'b01,
        FS_UPDATE = 2'b10,
        FS_ENABLE = 2'b11
    } strobe_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] high_cnt;
        logic [CNT_W-1:0] low_cnt;
        logic [REP_W-1:0] reps;
    } pattern_cfg_t;

    typedef struct packed {
        logic             run;
        logic             sel;
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [REP_W-1:0] rep;
    } seq_state_t;

    typedef struct packed {
        logic valid;
        logic sel;
    } start_t;

    // A zero count still occupies one clock.
    function automatic logic [CNT_W-1:0] phase_span(input logic [CNT_W-1:0] c);
        return (c == '0) ? CNT_W'(1) : c;
    endfunction

    function automatic logic phase_done(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] c);
        return cnt == (phase_span(c) - CNT_W'(1));
    endfunction

    // First pattern to play after an update; none when both counts are zero.
    function automatic start_t pick_start(input logic [REP_W-1:0] reps_a,
                                          input logic [REP_W-1:0] reps_b);
        start_t s;
        s.valid = (reps_a != '0) || (reps_b != '0);
        s.sel   = (reps_a == '0);
        return s;
    endfunction

endpackage

// File: rtl/txen_seq_core.sv
module txen_seq_core
    import txen_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         upd_i,
    input  pattern_cfg_t cfg_a,
    input  pattern_cfg_t cfg_b,
    output logic         raw_o
);

    seq_state_t   st;
    seq_state_t   st_nxt;
    pattern_cfg_t cur;
    pattern_cfg_t oth;
    start_t       first;

    always_comb begin
        cur   = st.sel ? cfg_b : cfg_a;
        oth   = st.sel ? cfg_a : cfg_b;
        first = pick_start(cfg_a.reps, cfg_b.reps);
    end

    always_comb begin
        st_nxt = st;
        if (upd_i) begin
            st_nxt.run = first.valid;
            st_nxt.sel = first.sel;
            st_nxt.ph  = PH_HIGH;
            st_nxt.cnt = '0;
            st_nxt.rep = '0;
        end else if (st.run) begin
            if (st.ph == PH_HIGH) begin
                if (phase_done(st.cnt, cur.high_cnt)) begin
                    st_nxt.ph  = PH_LOW;
                    st_nxt.cnt = '0;
                end else begin
                    st_nxt.cnt = st.cnt + CNT_W'(1);
                end
            end else begin
                if (phase_done(st.cnt, cur.low_cnt)) begin
                    st_nxt.ph  = PH_HIGH;
                    st_nxt.cnt = '0;
                    if (st.rep == (cur.reps - REP_W'(1))) begin
                        st_nxt.rep = '0;
                        if (oth.reps != '0) begin
                            st_nxt.sel = ~st.sel;
                        end
                    end else begin
                        st_nxt.rep = st.rep + REP_W'(1);
                    end
                end else begin
                    st_nxt.cnt = st.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.run <= 1'b0;
            st.sel <= 1'b0;
            st.ph  <= PH_HIGH;
            st.cnt <= '0;
            st.rep <= '0;
        end else begin
            st <= st_nxt;
        end
    end

    assign raw_o = st.run && (st.ph == PH_HIGH);

    AST_UPD_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (upd_i && ((cfg_a.reps != '0) || (cfg_b.reps != '0))) |=> raw_o); // R2

    AST_ALL_SKIPPED_LOW: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (cfg_a.reps == '0) && (cfg_b.reps == '0)) |=> !raw_o); // R5

    AST_PHASE_CNT_BOUND: assert property (@(posedge clk) disable iff (rst || upd_i)
        st.run |-> (st.cnt < phase_span((st.ph == PH_HIGH) ? cur.high_cnt : cur.low_cnt))); // R3

    AST_REP_BOUND: assert property (@(posedge clk) disable iff (rst || upd_i)
        st.run |-> (st.rep < cur.reps)); // R4

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> (st.cnt == '0) && (st.rep == '0) && (st.ph == PH_HIGH)); // R6

endmodule

// File: rtl/txen_pin_mux.sv
module txen_pin_mux
    import txen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic             upd_i,
    input  logic             sync_en,
    input  logic             pin_ctl_en,
    input  logic [SEL_W-1:0] mode_i,
    input  logic             fs_default_i,
    output logic             txen_o,
    output logic             fs_o
);

    logic        txen_q;
    strobe_sel_e sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            txen_q <= 1'b0;
        end else begin
            txen_q <= raw_i;
        end
    end

    assign txen_o = sync_en ? txen_q : raw_i;

    always_comb begin
        sel  = strobe_sel_e'(mode_i);
        fs_o = fs_default_i;
        if (pin_ctl_en) begin
            unique case (sel)
                FS_UPDATE: fs_o = upd_i;
                FS_ENABLE: fs_o = txen_o;
                default:   fs_o = fs_default_i;
            endcase
        end
    end

    AST_SYNC_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (sync_en && $past(sync_en)) |-> (txen_o == $past(raw_i))); // R7

endmodule

// File: rtl/txen_cycle_gen.sv
module txen_cycle_gen
    import txen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] pa_high_cnt,
    input  logic [CNT_W-1:0] pa_low_cnt,
    input  logic [CNT_W-1:0] pb_high_cnt,
    input  logic [CNT_W-1:0] pb_low_cnt,
    input  logic [REP_W-1:0] pa_reps,
    input  logic [REP_W-1:0] pb_reps,
    input  logic [SEL_W-1:0] strobe_mode,
    input  logic             upd_i,
    input  logic             pin_ctl_en,
    input  logic             sync_en,
    input  logic             fs_default_i,
    output logic             txen_o,
    output logic             fs_o
);

    pattern_cfg_t cfg_a;
    pattern_cfg_t cfg_b;
    logic         raw_en;

    always_comb begin
        cfg_a.high_cnt = pa_high_cnt;
        cfg_a.low_cnt  = pa_low_cnt;
        cfg_a.reps     = pa_reps;
        cfg_b.high_cnt = pb_high_cnt;
        cfg_b.low_cnt  = pb_low_cnt;
        cfg_b.reps     = pb_reps;
    end

    txen_seq_core u_seq (
        .clk   (clk),
        .rst   (rst),
        .upd_i (upd_i),
        .cfg_a (cfg_a),
        .cfg_b (cfg_b),
        .raw_o (raw_en)
    );

    txen_pin_mux u_pin (
        .clk          (clk),
        .rst          (rst),
        .raw_i        (raw_en),
        .upd_i        (upd_i),
        .sync_en      (sync_en),
        .pin_ctl_en   (pin_ctl_en),
        .mode_i       (strobe_mode),
        .fs_default_i (fs_default_i),
        .txen_o       (txen_o),
        .fs_o         (fs_o)
    );

endmodule

// File: tb/txen_cycle_gen_tb.sv
module txen_cycle_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ah = '0, al = '0, bh = '0, bl = '0;
    logic [4:0]  ar = '0, br = '0;
    logic [1:0]  mode = 2'b00;
    logic        upd = 1'b0, pce = 1'b0, sen = 1'b0, fsd = 1'b0;
    logic        txen, fs;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    txen_cycle_gen dut_i (
        .clk(clk), .rst(rst),
        .pa_high_cnt(ah), .pa_low_cnt(al), .pb_high_cnt(bh), .pb_low_cnt(bl),
        .pa_reps(ar), .pb_reps(br), .strobe_mode(mode), .upd_i(upd),
        .pin_ctl_en(pce), .sync_en(sen), .fs_default_i(fsd),
        .txen_o(txen), .fs_o(fs)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int span(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    // Expected enable k clocks after the update edge (k = 0 is the first cycle).
    function automatic logic model(input int k);
        int pa, pb, sa, sb, p, m;
        pa = span(int'(ah)) + span(int'(al));
        pb = span(int'(bh)) + span(int'(bl));
        sa = int'(ar) * pa;
        sb = int'(br) * pb;
        p  = sa + sb;
        if (p == 0) return 1'b0;
        m = k % p;
        if (m < sa) return (m % pa) < span(int'(ah));
        m = m - sa;
        return (m % pb) < span(int'(bh));
    endfunction

    function automatic int run_len();
        int p;
        p = int'(ar) * (span(int'(ah)) + span(int'(al)))
          + int'(br) * (span(int'(bh)) + span(int'(bl)));
        return (p == 0) ? 6 : 2 * p + 2;
    endfunction

    // Apply configuration together with the update pulse; returns in cycle k = 0.
    task automatic start(input int h0, input int l0, input int r0,
                         input int h1, input int l1, input int r1);
        @(negedge clk);
        ah = 16'(h0); al = 16'(l0); ar = 5'(r0);
        bh = 16'(h1); bl = 16'(l1); br = 5'(r1);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: idle after reset despite a nonzero configuration
        ah = 16'd2; al = 16'd2; ar = 5'd1; bh = 16'd1; bl = 16'd1; br = 5'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R1", txen, 1'b0);
        end

        // R2..R5 exhaustive sweep, R9 mode 11 follows the enable
        pce = 1'b1; mode = 2'b11; sen = 1'b0;
        for (int h0 = 0; h0 < 3; h0++)
        for (int l0 = 0; l0 < 3; l0++)
        for (int h1 = 0; h1 < 3; h1++)
        for (int l1 = 0; l1 < 3; l1++)
        for (int r0 = 0; r0 < 3; r0++)
        for (int r1 = 0; r1 < 3; r1++) begin
            start(h0, l0, r0, h1, l1, r1);
            n = run_len();
            for (int k = 0; k < n; k++) begin
                if (k == 0 && (r0 != 0 || r1 != 0)) chk("R2", txen, 1'b1);
                else if (r0 == 0 || r1 == 0)        chk("R5", txen, model(k));
                else if (k < 2 * (span(h0) + span(l0)) && r0 == 1)
                                                    chk("R3", txen, model(k));
                else                                chk("R4", txen, model(k));
                chk("R9", fs, txen);
                @(negedge clk);
            end
        end

        // R6: restart mid-run
        start(3, 2, 2, 1, 4, 1);
        repeat (7) @(negedge clk);
        start(3, 2, 2, 1, 4, 1);
        for (int k = 0; k < 30; k++) begin
            chk("R6", txen, model(k));
            @(negedge clk);
        end

        // R7: one-clock synchronizer delay
        start(0, 0, 0, 0, 0, 0);
        sen = 1'b1;
        for (int h0 = 1; h0 < 4; h0++)
        for (int l1 = 0; l1 < 3; l1++)
        for (int r0 = 1; r0 < 3; r0++) begin
            start(h0, 2, r0, 1, l1, 1);
            n = run_len();
            for (int k = 0; k < n; k++) begin
                if (k > 0) chk("R7", txen, model(k - 1));
                @(negedge clk);
            end
        end
        start(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        sen = 1'b0;

        // R8: pin control off, default passes for every mode
        pce = 1'b0;
        start(2, 1, 1, 1, 1, 1);
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            for (int d = 0; d < 2; d++) begin
                fsd = d[0];
                @(negedge clk);
                chk("R8", fs, fsd);
            end
        end

        // R9: modes 00/01 default, 10 update pulse
        pce = 1'b1;
        for (int m = 0; m < 2; m++) begin
            mode = 2'(m);
            for (int d = 0; d < 2; d++) begin
                fsd = d[0];
                @(negedge clk);
                chk("R9", fs, fsd);
            end
        end
        mode = 2'b10; fsd = 1'b1;
        @(negedge clk);
        chk("R9", fs, 1'b0);
        upd = 1'b1;
        #1;
        chk("R9", fs, 1'b1);
        @(negedge clk);
        upd = 1'b0;
        #1;
        chk("R9", fs, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule